// File: doc/BRIEF.md
# Supply Overvoltage Protection Sequencer

This block is the digital controller behind an input-supply protection switch. It receives two comparator results from the analog side: one that is high while the input sits above the undervoltage level, and one that is high while the input sits above the overvoltage level. From these it produces a gate-enable request for an external pass-transistor driver and an active-high fault flag.

When the input becomes valid, the block first waits a turn-on delay with the gate off. It then enables the gate and holds the fault flag high for a further blanking interval, after which it releases the flag and settles in the running state. A fault in any state drops the gate and raises the flag on the next decision, with no timed delay. Both intervals are counted in pulses of a one-cycle clock-enable tick, nominally 1 ms, and the number of ticks for each interval is a parameter.

Both comparator inputs pass through a two-flop synchronizer before any decision uses them. The current state is brought out as a 2-bit observation port.

Top module: `ovp_seq_top`

## Requirements
- R1: A synchronous active-high reset puts the block in the idle state: state output 0, gate enable low, fault flag high.
- R2: Each comparator input passes through two synchronizer flops. A change applied before clock edge k first affects the state and the outputs at edge k+2.
- R3: In the idle state (code 0), a valid input (undervoltage comparator high and overvoltage comparator low, as seen after synchronization) moves the block to the delay state (code 1) at the next edge.
- R4: In the delay state the gate enable is low and the flag is high. The block leaves for the blanking state (code 2) at the edge that samples the DELAY_TICKS-th tick counted in the delay state.
- R5: In the blanking state the gate enable is high and the flag is still high. The block enters the running state (code 3) at the edge that samples the BLANK_TICKS-th tick counted in the blanking state.
- R6: In the running state the gate enable is high and the flag is low. The block stays there while the input remains valid.
- R7: A synchronized overvoltage indication returns the block to idle at the next edge from any state, with the gate enable low and the flag high.
- R8: A synchronized loss of the undervoltage indication returns the block to idle at the next edge from any state.
- R9: The overvoltage indication takes priority: with both comparators high, the input is treated as a fault, and the block stays in idle.
- R10: A fault during the delay or blanking state clears the interval count, so a later valid input starts the full delay again from zero.
- R11: Cycles without a tick do not advance the interval count. Ticks seen in the idle or running state have no effect.
- R12: The state output encodes idle=0, delay=1, blanking=2, running=3.
- R13: The flag is low only while the gate enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle timebase enable, nominally once per millisecond |
| above_uv | input | 1 | Asynchronous comparator: input above the undervoltage level |
| above_ov | input | 1 | Asynchronous comparator: input above the overvoltage level |
| gate_en | output | 1 | Registered gate-enable request to the pass-transistor driver |
| fault_flag | output | 1 | Registered active-high fault indication |
| state_o | output | 2 | Current state code (idle=0, delay=1, blanking=2, running=3) |

## Verification
A wrong state shows at the ports within one clock, because gate_en, fault_flag and state_o are all registered from the next-state decision. A wrong interval count is invisible until the interval ends. It then shows as a transition that comes early or late by whole ticks, so the bench compares every cycle against a behavioural model and uses different tick counts for the two intervals. A count that is not cleared after an aborted sequence shows only on the next power-up, as a delay that ends too soon, and this is why faults are injected partway through an interval.

// File: rtl/ovp_seq_pkg.sv
package ovp_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_WAIT  = 2'd1,
    ST_BLANK = 2'd2,
    ST_RUN   = 2'd3
  } seq_state_t;
endpackage

// File: rtl/ovp_sync_chain.sv
module ovp_sync_chain #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) stg[0] <= '0;
          else     stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) stg[g] <= '0;
          else     stg[g] <= stg[g-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/ovp_interval_timer.sv
module ovp_interval_timer #(
  parameter int MAXL = 50,
  localparam int CW  = $clog2(MAXL + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          adv,
  input  logic [CW-1:0] last,
  output logic          expire
);
  logic [CW-1:0] cnt_q;

  assign expire = run && adv && (cnt_q == last);

  always_ff @(posedge clk) begin
    if (rst || !run || expire) cnt_q <= '0;
    else if (adv)              cnt_q <= cnt_q + 1'b1;
  end

  // R11: no tick, no movement of the count while running
  assert_tick_hold_R11: assert property (@(posedge clk) disable iff (rst)
    (run && !adv) |=> $stable(cnt_q));
  // R10: count is zero after any cycle that was not running
  assert_clear_R10: assert property (@(posedge clk) disable iff (rst)
    (!run) |=> (cnt_q == '0));
  assert_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CW'(MAXL));
endmodule

// File: rtl/ovp_seq_fsm.sv
module ovp_seq_fsm
  import ovp_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       uv_ok,
  input  logic       ov_hit,
  input  logic       expire,
  output logic       run,
  output logic       sel_blank,
  output logic       gate_en,
  output logic       fault_flag,
  output logic [1:0] state_o
);
  seq_state_t state_q, nxt;
  logic       valid;

  assign valid = uv_ok && !ov_hit;

  always_comb begin
    nxt = state_q;
    if (ov_hit)      nxt = ST_IDLE;
    else if (!uv_ok) nxt = ST_IDLE;
    else begin
      case (state_q)
        ST_IDLE:  nxt = ST_WAIT;
        ST_WAIT:  if (expire) nxt = ST_BLANK;
        ST_BLANK: if (expire) nxt = ST_RUN;
        default:  nxt = ST_RUN;
      endcase
    end
  end

  assign run       = valid && (state_q == ST_WAIT || state_q == ST_BLANK);
  assign sel_blank = (state_q == ST_BLANK);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q    <= ST_IDLE;
      gate_en    <= 1'b0;
      fault_flag <= 1'b1;
    end else begin
      state_q    <= nxt;
      gate_en    <= (nxt == ST_BLANK) || (nxt == ST_RUN);
      fault_flag <= (nxt != ST_RUN);
    end
  end

  assign state_o = state_q;

  assert_ov_drop_R7: assert property (@(posedge clk) disable iff (rst)
    ov_hit |=> (state_q == ST_IDLE && !gate_en && fault_flag));
  assert_uv_drop_R8: assert property (@(posedge clk) disable iff (rst)
    !uv_ok |=> (state_q == ST_IDLE && !gate_en && fault_flag));
  assert_idle_step_R3: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_IDLE && valid) |=> (state_q == ST_WAIT));
  assert_wait_gate_off_R4: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_WAIT) |-> (!gate_en && fault_flag));
  assert_blank_flag_R5: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_BLANK) |-> (gate_en && fault_flag));
  assert_run_out_R6: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_RUN) |-> (gate_en && !fault_flag));
  assert_flag_gate_R13: assert property (@(posedge clk) disable iff (rst)
    !fault_flag |-> gate_en);
endmodule

// File: rtl/ovp_seq_top.sv
module ovp_seq_top #(
  parameter int DELAY_TICKS = 50,
  parameter int BLANK_TICKS = 50,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       tick,
  input  logic       above_uv,
  input  logic       above_ov,
  output logic       gate_en,
  output logic       fault_flag,
  output logic [1:0] state_o
);
  localparam int MAXL = (DELAY_TICKS > BLANK_TICKS) ? DELAY_TICKS : BLANK_TICKS;
  localparam int CW   = $clog2(MAXL + 1);
  localparam logic [CW-1:0] WAIT_LAST  = CW'(DELAY_TICKS - 1);
  localparam logic [CW-1:0] BLANK_LAST = CW'(BLANK_TICKS - 1);

  logic [1:0]    cmp_s;
  logic          run, sel_blank, expire;
  logic [CW-1:0] last;

  ovp_sync_chain #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({above_ov, above_uv}),
    .q   (cmp_s)
  );

  assign last = sel_blank ? BLANK_LAST : WAIT_LAST;

  ovp_interval_timer #(.MAXL(MAXL)) u_timer (
    .clk    (clk),
    .rst    (rst),
    .run    (run),
    .adv    (tick),
    .last   (last),
    .expire (expire)
  );

  ovp_seq_fsm u_fsm (
    .clk        (clk),
    .rst        (rst),
    .uv_ok      (cmp_s[0]),
    .ov_hit     (cmp_s[1]),
    .expire     (expire),
    .run        (run),
    .sel_blank  (sel_blank),
    .gate_en    (gate_en),
    .fault_flag (fault_flag),
    .state_o    (state_o)
  );
endmodule

// File: tb/ovp_seq_top_tb_top.sv
module ovp_seq_top_tb_top;
  localparam int DT = 5;
  localparam int BT = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic tick = 1'b0;
  logic above_uv = 1'b0;
  logic above_ov = 1'b0;
  logic gate_en, fault_flag;
  logic [1:0] state_o;

  int errors = 0;
  int checks = 0;
  string cur_req = "R1";
  bit tick_en = 1'b0;
  int tphase = 0;
  bit finished = 1'b0;

  // behavioural model state
  int m_state = 0;
  int m_cnt = 0;
  bit uvq[$];
  bit ovq[$];

  always #4 clk = ~clk;

  ovp_seq_top #(.DELAY_TICKS(DT), .BLANK_TICKS(BT)) dut_i (
    .clk(clk), .rst(rst), .tick(tick), .above_uv(above_uv), .above_ov(above_ov),
    .gate_en(gate_en), .fault_flag(fault_flag), .state_o(state_o)
  );

  // tick: one cycle in three while enabled
  always @(negedge clk) begin
    if (tick_en) begin
      tick <= (tphase == 2);
      tphase <= (tphase + 1) % 3;
    end else begin
      tick <= 1'b0;
    end
  end

  // reference model, updated at each edge
  always @(posedge clk) begin
    bit uv2, ov2;
    if (rst) begin
      m_state = 0; m_cnt = 0;
      uvq = '{0, 0}; ovq = '{0, 0};
    end else begin
      uv2 = uvq[0]; ov2 = ovq[0];
      if (ov2 || !uv2) begin
        m_state = 0; m_cnt = 0;
      end else begin
        case (m_state)
          0: begin m_state = 1; m_cnt = 0; end
          1: if (tick) begin
               if (m_cnt == DT - 1) begin m_state = 2; m_cnt = 0; end
               else m_cnt++;
             end
          2: if (tick) begin
               if (m_cnt == BT - 1) begin m_state = 3; m_cnt = 0; end
               else m_cnt++;
             end
          default: m_state = 3;
        endcase
      end
      void'(uvq.pop_front()); uvq.push_back(above_uv);
      void'(ovq.pop_front()); ovq.push_back(above_ov);
    end
  end

  // compare every cycle, away from the edge (R12 state codes, R13 outputs)
  always @(posedge clk) begin
    #2;
    if (!finished) begin
      checks++;
      if (state_o !== 2'(m_state) || gate_en !== (m_state >= 2) || fault_flag !== (m_state != 3)) begin
        errors++;
        $display("FAIL %s/R12/R13 state=%0d gate=%0b flag=%0b expected state=%0d gate=%0b flag=%0b",
                 cur_req, state_o, gate_en, fault_flag, m_state, (m_state >= 2), (m_state != 3));
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_state(input string req, input int exp);
    checks++;
    if (state_o !== 2'(exp)) begin
      errors++;
      $display("FAIL %s state=%0d expected=%0d", req, state_o, exp);
    end
  endtask

  initial begin
    // R1 reset
    cur_req = "R1";
    cyc(4);
    rst = 1'b0;
    cyc(1);
    expect_state("R1", 0);
    // R2/R3 sync latency then step to delay
    cur_req = "R2";
    above_uv = 1'b1;
    cyc(2);
    expect_state("R2", 0);
    cyc(1);
    expect_state("R3", 1);
    // R11: no ticks, delay holds
    cur_req = "R11";
    cyc(30);
    expect_state("R11", 1);
    // R4/R5 timed phases
    cur_req = "R4";
    tick_en = 1'b1;
    cyc(3 * DT + 2);
    cur_req = "R5";
    cyc(3 * BT + 3);
    expect_state("R5", 3);
    // R6 hold in running, ticks ignored
    cur_req = "R6";
    cyc(25);
    expect_state("R6", 3);
    // R7 overvoltage from running
    cur_req = "R7";
    above_ov = 1'b1;
    cyc(3);
    expect_state("R7", 0);
    above_ov = 1'b0;
    // R10 fault in mid delay, then full restart
    cur_req = "R10";
    cyc(3 + 3 * (DT - 2));
    above_ov = 1'b1;
    cyc(4);
    above_ov = 1'b0;
    cyc(3 * DT + 6);
    // R8 undervoltage loss in blanking
    cur_req = "R8";
    cyc(3);
    above_uv = 1'b0;
    cyc(3);
    expect_state("R8", 0);
    // R9 both high is a fault
    cur_req = "R9";
    above_uv = 1'b1;
    above_ov = 1'b1;
    cyc(20);
    expect_state("R9", 0);
    above_uv = 1'b0;
    cyc(10);
    above_ov = 1'b0;
    above_uv = 1'b1;
    cur_req = "R6";
    cyc(3 * (DT + BT) + 12);
    expect_state("R6", 3);
    // reset from running
    cur_req = "R1";
    rst = 1'b1;
    cyc(2);
    expect_state("R1", 0);
    rst = 1'b0;
    cyc(5);
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 8);
    if (!finished) begin
      finished = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule